// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block takes a bank of external interrupt lines and turns each detected assertion into a delivery message for a processor destination. Every line has its own redirection entry. The entry sets the mask, the trigger mode (edge or level), the polarity, the vector, the destination field and whether that field is a physical unit ID or a logical destination.

Software reaches every internal register through a two-step window. It first writes a register number into the index location at byte offset 0x00. Each later access to the data location at byte offset 0x10 then targets the register that number selects. Identification and version registers come first. The redirection entries follow as low/high word pairs.

Detected interrupts leave one at a time as a message with a valid/ready handshake. When several lines request at once, the lowest-numbered line wins. A level-triggered line stays blocked after delivery until an end-of-interrupt with its vector arrives.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset the identification register reads the parameter ID_RESET in bits 31:24 with all other bits zero. Every redirection low word reads 0x0001_0000 (mask set, all else zero). Every high word reads zero, and msg_valid is low.
- R2: A write to byte offset 0x00 stores wdata[7:0] as the current index, and a read at 0x00 returns it in bits 7:0. Reads and writes at 0x10 act on the register that index selects. In the identification register (index 0x00) only bits 31:24 are writable.
- R3: The version register (index 0x01) reads NUM_IN-1 in bits 23:16 and VER_CODE in bits 7:0, with all other bits zero. Writes to it have no effect.
- R4: Input n has its low word at index 0x10+2n and its high word at 0x10+2n+1. In the low word: bit 16 is the mask, bit 15 selects level mode, bit 14 is the read-only remote-IRR status, bit 13 selects active-low, bit 11 selects logical destination mode, and bits 7:0 are the vector. In the high word, bits 31:24 are the destination. All other bits read zero.
- R5: Indices that hold no register (0x02–0x0F and from 0x10+2·NUM_IN upward) read zero, and writes to them change nothing.
- R6: An unmasked edge-mode line produces one message per inactive-to-active transition. Any further transitions that occur before that message is accepted merge into it.
- R7: With the active-low bit set, low is the active level, so an edge-mode entry fires on a falling transition and not on a rising one.
- R8: A masked line produces no message, and an edge seen while the line is masked is not remembered after unmasking.
- R9: An unmasked level-mode line is delivered while active with remote-IRR clear. Acceptance sets remote-IRR, which blocks redelivery. An end-of-interrupt with a different vector leaves it set. One with the matching vector clears it, and the line is redelivered if it is still active.
- R10: A message carries the entry's vector on msg_vector, its destination on msg_dest and its destination mode on msg_logical.
- R11: When several lines request in the same cycle, the lowest-numbered line is delivered first. A presented message keeps valid and all fields stable until msg_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register write strobe |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 5 | Byte offset: 0x00 index, 0x10 data |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for acc_addr (combinational) |
| irq_in | input | NUM_IN | Asynchronous interrupt lines |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |
| msg_valid | output | 1 | Delivery message present |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Delivered vector |
| msg_dest | output | 8 | Delivered destination |
| msg_logical | output | 1 | Destination mode: 1 logical, 0 physical |

## Verification
If a pending bit or a remote-IRR bit is corrupted, the effect shows at the message port as a missing, extra or repeated delivery. This appears within about five cycles of the line change or the end-of-interrupt, and a low-word read shows bit 14 directly. Faults in the arbitration order or the holding register show up as messages in the wrong order, or as fields that change while ready is low. Faults in index decoding appear on the next data read as wrong or aliased register contents.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam logic [4:0] OFS_INDEX = 5'h00;
    localparam logic [4:0] OFS_DATA  = 5'h10;

    localparam logic [7:0] IDX_ID  = 8'h00;
    localparam logic [7:0] IDX_VER = 8'h01;
    localparam logic [7:0] IDX_TBL = 8'h10;

    localparam int B_MASK    = 16;
    localparam int B_LEVEL   = 15;
    localparam int B_IRR     = 14;
    localparam int B_ACTLOW  = 13;
    localparam int B_LOGICAL = 11;

    typedef struct packed {
        logic       mask;
        logic       level;
        logic       act_low;
        logic       logical;
        logic [7:0] vector;
        logic [7:0] dest;
    } redir_t;

    typedef struct packed {
        logic [7:0] vector;
        logic [7:0] dest;
        logic       logical;
        logic       level;
    } msg_t;

    localparam redir_t REDIR_RESET = '{mask: 1'b1, default: '0};

    function automatic logic [31:0] low_word(redir_t e, logic irr);
        logic [31:0] w;
        w            = '0;
        w[B_MASK]    = e.mask;
        w[B_LEVEL]   = e.level;
        w[B_IRR]     = irr;
        w[B_ACTLOW]  = e.act_low;
        w[B_LOGICAL] = e.logical;
        w[7:0]       = e.vector;
        return w;
    endfunction

    function automatic redir_t apply_low(redir_t e, logic [31:0] w);
        redir_t r;
        r         = e;
        r.mask    = w[B_MASK];
        r.level   = w[B_LEVEL];
        r.act_low = w[B_ACTLOW];
        r.logical = w[B_LOGICAL];
        r.vector  = w[7:0];
        return r;
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int         NUM_IN   = 24,
    parameter logic [7:0] ID_RESET = 8'h00,
    parameter logic [7:0] VER_CODE = 8'h20
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      acc_valid,
    input  logic                      acc_write,
    input  logic [4:0]                acc_addr,
    input  logic [31:0]               acc_wdata,
    output logic [31:0]               acc_rdata,
    input  logic [NUM_IN-1:0]         irr_set,
    input  logic                      eoi_valid,
    input  logic [7:0]                eoi_vector,
    output redir_t [NUM_IN-1:0]       entries,
    output logic [NUM_IN-1:0]         irr
);
    localparam int SEL_W   = $clog2(NUM_IN);
    localparam int TBL_END = 16 + 2 * NUM_IN;

    logic [7:0]       index_q;
    logic [7:0]       unit_id_q;
    logic [7:0]       tbl_off;
    logic [SEL_W-1:0] sel;
    logic             in_tbl;
    logic             hi_word;
    logic             wr_index;
    logic             wr_data;
    logic [31:0]      data_sel;

    assign wr_index = acc_valid && acc_write && (acc_addr == OFS_INDEX);
    assign wr_data  = acc_valid && acc_write && (acc_addr == OFS_DATA);
    assign tbl_off  = index_q - IDX_TBL;
    assign sel      = tbl_off[SEL_W:1];
    assign hi_word  = tbl_off[0];
    assign in_tbl   = (index_q >= IDX_TBL) && (int'(index_q) < TBL_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q   <= '0;
            unit_id_q <= ID_RESET;
        end else begin
            if (wr_index)
                index_q <= acc_wdata[7:0];
            if (wr_data && index_q == IDX_ID)
                unit_id_q <= acc_wdata[31:24];
        end
    end

    for (genvar i = 0; i < NUM_IN; i++) begin : g_entry
        logic hit;
        assign hit = wr_data && in_tbl && (sel == SEL_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                entries[i] <= REDIR_RESET;
                irr[i]     <= 1'b0;
            end else begin
                if (hit && hi_word)
                    entries[i].dest <= acc_wdata[31:24];
                else if (hit)
                    entries[i] <= apply_low(entries[i], acc_wdata);
                if (irr_set[i])
                    irr[i] <= 1'b1;
                else if (eoi_valid && eoi_vector == entries[i].vector)
                    irr[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        data_sel = '0;
        if (index_q == IDX_ID)
            data_sel = {unit_id_q, 24'h0};
        else if (index_q == IDX_VER)
            data_sel = {8'h0, 8'(NUM_IN - 1), 8'h0, VER_CODE};
        else if (in_tbl && hi_word)
            data_sel = {entries[sel].dest, 24'h0};
        else if (in_tbl)
            data_sel = low_word(entries[sel], irr[sel]);
    end

    always_comb begin
        case (acc_addr)
            OFS_INDEX: acc_rdata = {24'h0, index_q};
            OFS_DATA:  acc_rdata = data_sel;
            default:   acc_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_route_cond.sv
module irq_route_cond
    import irq_route_pkg::*;
#(
    parameter int NUM_IN = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_IN-1:0]   irq_in,
    input  redir_t [NUM_IN-1:0] entries,
    input  logic [NUM_IN-1:0]   irr,
    input  logic [NUM_IN-1:0]   deliver,
    output logic [NUM_IN-1:0]   req
);
    for (genvar i = 0; i < NUM_IN; i++) begin : g_line
        logic s1, s2, act, act_q, pend;

        assign act = s2 ^ entries[i].act_low;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1    <= 1'b0;
                s2    <= 1'b0;
                act_q <= 1'b0;
                pend  <= 1'b0;
            end else begin
                s1    <= irq_in[i];
                s2    <= s1;
                act_q <= act;
                if (!entries[i].mask && !entries[i].level && act && !act_q)
                    pend <= 1'b1;
                else if (deliver[i])
                    pend <= 1'b0;
            end
        end

        assign req[i] = !entries[i].mask &&
                        (entries[i].level ? (act && !irr[i]) : pend);
    end

endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb
    import irq_route_pkg::*;
#(
    parameter int NUM_IN = 24,
    localparam int SRC_W = $clog2(NUM_IN)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_IN-1:0]   req,
    input  redir_t [NUM_IN-1:0] entries,
    input  logic                msg_ready,
    output logic                msg_valid,
    output msg_t                hold,
    output logic [SRC_W-1:0]    hold_src,
    output logic [NUM_IN-1:0]   deliver,
    output logic [NUM_IN-1:0]   irr_set
);
    logic [SRC_W-1:0] pick;
    logic             accept;

    always_comb begin
        pick = '0;
        for (int i = NUM_IN - 1; i >= 0; i--)
            if (req[i]) pick = SRC_W'(i);
    end

    assign accept = msg_valid && msg_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            hold      <= '0;
            hold_src  <= '0;
        end else if (accept) begin
            msg_valid <= 1'b0;
        end else if (!msg_valid && |req) begin
            msg_valid    <= 1'b1;
            hold_src     <= pick;
            hold.vector  <= entries[pick].vector;
            hold.dest    <= entries[pick].dest;
            hold.logical <= entries[pick].logical;
            hold.level   <= entries[pick].level;
        end
    end

    always_comb begin
        deliver = '0;
        if (accept) deliver[hold_src] = 1'b1;
        irr_set = deliver & {NUM_IN{hold.level}};
    end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int         NUM_IN   = 24,
    parameter logic [7:0] ID_RESET = 8'h00,
    parameter logic [7:0] VER_CODE = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [4:0]        acc_addr,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       acc_rdata,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              eoi_valid,
    input  logic [7:0]        eoi_vector,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [7:0]        msg_vector,
    output logic [7:0]        msg_dest,
    output logic              msg_logical
);
    localparam int SRC_W = $clog2(NUM_IN);

    redir_t [NUM_IN-1:0] entries;
    logic [NUM_IN-1:0]   irr;
    logic [NUM_IN-1:0]   req;
    logic [NUM_IN-1:0]   deliver;
    logic [NUM_IN-1:0]   irr_set;
    logic [NUM_IN-1:0]   mask_vec;
    msg_t                hold;
    logic [SRC_W-1:0]    hold_src;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_mask
        assign mask_vec[i] = entries[i].mask;
    end

    irq_route_regs #(.NUM_IN(NUM_IN), .ID_RESET(ID_RESET), .VER_CODE(VER_CODE)) u_regs (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .irr_set(irr_set), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .entries(entries), .irr(irr)
    );

    irq_route_cond #(.NUM_IN(NUM_IN)) u_cond (
        .clk(clk), .rst(rst), .irq_in(irq_in), .entries(entries),
        .irr(irr), .deliver(deliver), .req(req)
    );

    irq_route_arb #(.NUM_IN(NUM_IN)) u_arb (
        .clk(clk), .rst(rst), .req(req), .entries(entries),
        .msg_ready(msg_ready), .msg_valid(msg_valid), .hold(hold),
        .hold_src(hold_src), .deliver(deliver), .irr_set(irr_set)
    );

    assign msg_vector  = hold.vector;
    assign msg_dest    = hold.dest;
    assign msg_logical = hold.logical;

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int NUM_IN = 24,
    localparam int SRC_W = $clog2(NUM_IN)
) (
    input logic              clk,
    input logic              rst,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [7:0]        msg_vector,
    input logic [7:0]        msg_dest,
    input logic              msg_logical,
    input logic              hold_level,
    input logic [SRC_W-1:0]  hold_src,
    input logic [NUM_IN-1:0] req_vec,
    input logic [NUM_IN-1:0] mask_vec,
    input logic [NUM_IN-1:0] irr_vec
);
    logic [NUM_IN-1:0] req_q, mask_q, below;
    logic [SRC_W-1:0]  src_q;
    logic              rst_q;

    always_ff @(posedge clk) begin
        req_q  <= req_vec;
        mask_q <= mask_vec;
        src_q  <= hold_src;
        rst_q  <= rst;
    end

    always_comb begin
        below = '0;
        for (int i = 0; i < NUM_IN; i++)
            if (SRC_W'(i) < hold_src) below[i] = 1'b1;
    end

    // R1: no message right after reset
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> !msg_valid);

    // R11: message held stable while not accepted
    p_hold_stable_r11: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=>
        (msg_valid && $stable(msg_vector) && $stable(msg_dest) && $stable(msg_logical)));

    // R11: newly loaded message comes from the lowest requesting line
    p_lowest_wins_r11: assert property (@(posedge clk) disable iff (rst || rst_q)
        $rose(msg_valid) |-> (req_q[hold_src] && ((req_q & below) == '0)));

    // R8: a loaded line was unmasked when chosen
    p_unmasked_src_r8: assert property (@(posedge clk) disable iff (rst || rst_q)
        $rose(msg_valid) |-> !mask_q[hold_src]);

    // R9: accepted level delivery sets remote-IRR
    p_irr_set_r9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready && hold_level) |=> irr_vec[src_q]);

    // R9: an outstanding level message never has remote-IRR already set
    p_no_redeliver_r9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && hold_level) |-> !irr_vec[hold_src]);

endmodule

bind irq_route_ctrl irq_route_chk #(.NUM_IN(NUM_IN)) i_chk (
    .clk(clk), .rst(rst),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_logical(msg_logical),
    .hold_level(hold.level), .hold_src(hold_src),
    .req_vec(req), .mask_vec(mask_vec), .irr_vec(irr)
);

// File: tb/test_irq_route_ctrl.sv
module test_irq_route_ctrl;
    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [4:0]  acc_addr = 5'h10;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [N-1:0] irq = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        msg_valid, msg_ready = 1'b1;
    logic [7:0]  msg_vector, msg_dest;
    logic        msg_logical;

    int tests = 0, fails = 0;

    typedef struct packed { logic [7:0] v; logic [7:0] d; logic l; } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    irq_route_ctrl #(.NUM_IN(N), .ID_RESET(8'h05), .VER_CODE(8'h20)) i_irq_route_ctrl (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .irq_in(irq), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_dest(msg_dest), .msg_logical(msg_logical)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: R10 content and ordering, unexpected deliveries
    always @(negedge clk) begin
        if (!rst && msg_valid && msg_ready) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R6/R8/R9 unexpected message actual=%h expected=none", msg_vector);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                if (msg_vector !== e.v || msg_dest !== e.d || msg_logical !== e.l) begin
                    fails++;
                    $display("FAIL R10 actual=%h/%h/%b expected=%h/%h/%b",
                             msg_vector, msg_dest, msg_logical, e.v, e.d, e.l);
                end
            end
        end
    end

    task automatic expect_msg(logic [7:0] v, logic [7:0] d, logic l);
        exp_q.push_back('{v: v, d: d, l: l});
    endtask

    task automatic bus_write(logic [4:0] a, logic [31:0] d);
        @(posedge clk); #1;
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
        @(posedge clk); #1;
        acc_valid = 1'b0; acc_write = 1'b0; acc_addr = 5'h10;
    endtask

    task automatic reg_write(logic [7:0] idx, logic [31:0] d);
        bus_write(5'h00, {24'h0, idx});
        bus_write(5'h10, d);
    endtask

    task automatic reg_read(logic [7:0] idx, output logic [31:0] d);
        bus_write(5'h00, {24'h0, idx});
        @(negedge clk);
        d = acc_rdata;
    endtask

    task automatic set_line(int n, logic v);
        @(posedge clk); #1;
        irq[n] = v;
    endtask

    task automatic eoi(logic [7:0] v);
        @(posedge clk); #1;
        eoi_valid = 1'b1; eoi_vector = v;
        @(posedge clk); #1;
        eoi_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 msg_valid", {31'b0, msg_valid}, 0);
        reg_read(8'h00, r); chk("R1 id", r, 32'h0500_0000);
        reg_read(8'h10, r); chk("R1 low0", r, 32'h0001_0000);
        reg_read(8'h11, r); chk("R1 high0", r, 0);
        reg_read(8'h3E, r); chk("R1 low23", r, 32'h0001_0000);

        // R2 window, R3 version
        bus_write(5'h00, 32'h0000_0012);
        @(negedge clk); acc_addr = 5'h00; #1;
        chk("R2 index readback", acc_rdata, 32'h12);
        acc_addr = 5'h10;
        reg_write(8'h00, 32'hAB12_3456);
        reg_read(8'h00, r); chk("R2 id write", r, 32'hAB00_0000);
        reg_read(8'h01, r); chk("R3 version", r, 32'h0017_0020);
        reg_write(8'h01, 32'hFFFF_FFFF);
        reg_read(8'h01, r); chk("R3 version ro", r, 32'h0017_0020);

        // R4 field layout
        reg_write(8'h12, 32'hFFFF_FFFF);
        reg_read(8'h12, r); chk("R4 low fields", r, 32'h0001_A8FF);
        reg_write(8'h13, 32'hFFFF_FFFF);
        reg_read(8'h13, r); chk("R4 high fields", r, 32'hFF00_0000);

        // R5 unimplemented indices
        reg_write(8'h02, 32'hFFFF_FFFF);
        reg_read(8'h02, r); chk("R5 idx02", r, 0);
        reg_write(8'h40, 32'hFFFF_FFFF);
        reg_read(8'h40, r); chk("R5 idx40", r, 0);
        reg_read(8'h3E, r); chk("R5 no alias", r, 32'h0001_0000);

        // R6/R10 edge input 3, vector 0x43 dest 0x02 physical
        reg_write(8'h17, 32'h0200_0000);
        reg_write(8'h16, 32'h0000_0043);
        expect_msg(8'h43, 8'h02, 1'b0);
        set_line(3, 1); idle(4); set_line(3, 0); idle(10);
        chk("R6 single edge", exp_q.size(), 0);

        // R6 merge while not accepted
        @(posedge clk); #1 msg_ready = 1'b0;
        expect_msg(8'h43, 8'h02, 1'b0);
        for (int k = 0; k < 3; k++) begin
            set_line(3, 1); idle(4); set_line(3, 0); idle(4);
        end
        idle(6);
        @(posedge clk); #1 msg_ready = 1'b1;
        idle(12);
        chk("R6 merge", exp_q.size(), 0);

        // R7 active-low input 5, logical dest 0x81
        reg_write(8'h1B, 32'h8100_0000);
        reg_write(8'h1A, 32'h0001_2855);
        set_line(5, 1); idle(6);
        reg_write(8'h1A, 32'h0000_2855);
        idle(6);
        expect_msg(8'h55, 8'h81, 1'b1);
        set_line(5, 0); idle(10);
        chk("R7 falling fires", exp_q.size(), 0);
        set_line(5, 1); idle(10);
        @(negedge clk); chk("R7 rising quiet", {31'b0, msg_valid}, 0);

        // R8 masked edge not remembered
        reg_write(8'h1C, 32'h0001_0066);
        set_line(6, 1); idle(4); set_line(6, 0); idle(6);
        reg_write(8'h1C, 32'h0000_0066);
        idle(10);
        @(negedge clk); chk("R8 masked quiet", {31'b0, msg_valid}, 0);

        // R9 level input 8
        reg_write(8'h21, 32'h0300_0000);
        reg_write(8'h20, 32'h0000_8048);
        expect_msg(8'h48, 8'h03, 1'b0);
        set_line(8, 1); idle(10);
        chk("R9 first delivery", exp_q.size(), 0);
        reg_read(8'h20, r); chk("R9 irr set", r, 32'h0000_C048);
        idle(10);
        eoi(8'h47); idle(8);
        reg_read(8'h20, r); chk("R9 other eoi", r, 32'h0000_C048);
        expect_msg(8'h48, 8'h03, 1'b0);
        eoi(8'h48); idle(10);
        chk("R9 redelivery", exp_q.size(), 0);
        set_line(8, 0); idle(4);
        eoi(8'h48); idle(8);
        reg_read(8'h20, r); chk("R9 irr cleared", r, 32'h0000_8048);
        @(negedge clk); chk("R9 no message", {31'b0, msg_valid}, 0);

        // R11 priority and hold
        reg_write(8'h24, 32'h0000_004A);
        reg_write(8'h28, 32'h0000_004C);
        @(posedge clk); #1 msg_ready = 1'b0;
        expect_msg(8'h4A, 8'h00, 1'b0);
        expect_msg(8'h4C, 8'h00, 1'b0);
        @(posedge clk); #1 irq[10] = 1'b1; irq[12] = 1'b1;
        idle(8);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R11 hold", {23'b0, msg_valid, msg_vector}, {23'b0, 1'b1, 8'h4A});
        end
        @(posedge clk); #1 msg_ready = 1'b1;
        idle(12);
        chk("R11 both delivered", exp_q.size(), 0);

        summary();
    end

endmodule